// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory and Peripheral Access Port

This block lets a host reach device-internal storage that is not mapped into its own address space. It has two windows. The memory window has its own read pointer and its own write pointer. The host loads a pointer and then streams dwords through the matching data register. Every data access moves that pointer on by four bytes. The peripheral window takes a 16-bit register offset together with a transfer size of one to four bytes, and moves a single access per data-register touch.

The internal resources behind the windows may be powered down. For that reason an access-granted input gates every internal transfer. Without the grant, data reads return all ones, data writes are dropped, the pointers hold, and a sticky error flag is raised. Internal transfers use a single-outstanding request with a ready handshake. The host must wait for `busy` to fall before issuing its next register access.

Top module: `mem_window_port`

## Requirements
- R1: After reset, both memory pointers, both peripheral address registers, `acc_err`, `busy` and `ireq_valid` are zero.
- R2: A granted host write to the write-data register (offset 0x18) issues one internal memory write at the write pointer, with all four byte enables (0xF) and the host data.
- R3: Each granted write-data access advances the write pointer (read back at offset 0x10) by 4. Writing offset 0x10 loads the pointer.
- R4: A granted write to the read-address register (offset 0x0C) loads the read pointer and launches an internal read there. The first read of the read-data register (offset 0x1C) returns the dword at that address.
- R5: Each granted read-data access returns the buffered dword, advances the read pointer by 4 and prefetches the next dword. The read and write pointers never affect each other.
- R6: A peripheral address register holds an offset in bits 15:0 and (byte count − 1) in bits 25:24. A granted write to the peripheral write-data register (offset 0x4C) issues an internal peripheral write at the offset from register 0x44, with byte enables set for only the low (count+1) byte lanes.
- R7: A granted read of the peripheral read-data register (offset 0x50) issues an internal peripheral read at the offset from register 0x48. It answers once the internal read completes, with the bytes above the count forced to zero.
- R8: Without the grant, data-register reads return 0xFFFFFFFF, data-register writes issue no internal request, no pointer moves, and `acc_err` becomes 1 and stays 1 until reset.
- R9: An internal request keeps `ireq_valid`, address and data steady until `ireq_ready` is seen.
- R10: Reading offsets 0x44 or 0x48 returns only the offset and count fields, with all other bits zero.
- R11: Any host read other than a granted peripheral data read answers with `hreg_rvalid` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_grant | input | 1 | Internal resources are powered and may be accessed |
| hreg_wr | input | 1 | Host register write strobe |
| hreg_rd | input | 1 | Host register read strobe |
| hreg_addr | input | 8 | Host register byte offset |
| hreg_wdata | input | 32 | Host write data |
| hreg_rdata | output | 32 | Host read data |
| hreg_rvalid | output | 1 | Host read data valid |
| busy | output | 1 | Internal transfer outstanding; host must hold off |
| acc_err | output | 1 | Sticky flag: data access without grant |
| ireq_valid | output | 1 | Internal request pending |
| ireq_we | output | 1 | Internal request is a write |
| ireq_periph | output | 1 | Internal request targets the peripheral space |
| ireq_addr | output | 32 | Internal byte address |
| ireq_be | output | 4 | Internal byte enables |
| ireq_wdata | output | 32 | Internal write data |
| ireq_ready | input | 1 | Internal side accepts or completes the request |
| ireq_rdata | input | 32 | Internal read data, valid with ready |

## Verification
The assertions assume the host never issues a register access while `busy` is high, and never asserts read and write strobes in the same cycle. The stimulus follows both rules: every host task first waits for `busy` to fall, then drives exactly one strobe for exactly one cycle. The internal responder is also assumed to raise `ireq_ready` only while a request is pending. The bench model does so, and it can stretch its latency so that request holding is exercised.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int STEP   = BE_W;

  localparam logic [7:0] OFF_M_RPTR = 8'h0C;
  localparam logic [7:0] OFF_M_WPTR = 8'h10;
  localparam logic [7:0] OFF_M_WDAT = 8'h18;
  localparam logic [7:0] OFF_M_RDAT = 8'h1C;
  localparam logic [7:0] OFF_P_WADR = 8'h44;
  localparam logic [7:0] OFF_P_RADR = 8'h48;
  localparam logic [7:0] OFF_P_WDAT = 8'h4C;
  localparam logic [7:0] OFF_P_RDAT = 8'h50;

  typedef struct packed {
    logic [1:0]  cnt;
    logic [15:0] off;
  } padr_t;

  function automatic logic [BE_W-1:0] cnt_to_be(input logic [1:0] cnt);
    logic [BE_W:0] one_hot;
    one_hot = (BE_W+1)'(1) << (cnt + 2'd1 == 2'd0 ? 3'd4 : {1'b0, cnt + 2'd1});
    return BE_W'(one_hot - (BE_W+1)'(1));
  endfunction

  function automatic logic [DATA_W-1:0] be_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/imw_ptr.sv
module imw_ptr #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= ld_val;
    else if (step) q <= q + W'(STEP);
  end
endmodule

// File: rtl/imw_xfer.sv
module imw_xfer #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          l_we,
  input  logic          l_per,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic [BW-1:0] l_be,
  input  logic          ready,
  output logic          valid,
  output logic          we,
  output logic          per,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [BW-1:0] be,
  output logic          cmpl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      we    <= 1'b0;
      per   <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      be    <= '0;
    end else if (launch) begin
      valid <= 1'b1;
      we    <= l_we;
      per   <= l_per;
      addr  <= l_addr;
      wdata <= l_wdata;
      be    <= l_be;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign cmpl = valid & ready;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(wdata) && $stable(be)));
endmodule

// File: rtl/mem_window_port.sv
module mem_window_port
  import mwp_pkg::*;
#(
  parameter int HA_W = 8,
  parameter int IA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_grant,
  input  logic              hreg_wr,
  input  logic              hreg_rd,
  input  logic [HA_W-1:0]   hreg_addr,
  input  logic [DATA_W-1:0] hreg_wdata,
  output logic [DATA_W-1:0] hreg_rdata,
  output logic              hreg_rvalid,
  output logic              busy,
  output logic              acc_err,
  output logic              ireq_valid,
  output logic              ireq_we,
  output logic              ireq_periph,
  output logic [IA_W-1:0]   ireq_addr,
  output logic [BE_W-1:0]   ireq_be,
  output logic [DATA_W-1:0] ireq_wdata,
  input  logic              ireq_ready,
  input  logic [DATA_W-1:0] ireq_rdata
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [IA_W-1:0]   rptr, wptr;
  padr_t             pwa, pra;
  logic [DATA_W-1:0] rbuf;
  logic              prd_wait;
  logic              cmpl;

  logic              r_load, r_step, w_load, w_step;
  logic              launch, l_we, l_per, deny;
  logic [IA_W-1:0]   l_addr;
  logic [DATA_W-1:0] l_wdata;
  logic [BE_W-1:0]   l_be;

  wire is_wr = hreg_wr && !busy;
  wire is_rd = hreg_rd && !busy;

  always_comb begin
    r_load = 1'b0; r_step = 1'b0; w_load = 1'b0; w_step = 1'b0;
    launch = 1'b0; l_we = 1'b0; l_per = 1'b0; deny = 1'b0;
    l_addr = '0;   l_wdata = hreg_wdata; l_be = '1;
    if (is_wr) begin
      unique case (hreg_addr)
        OFF_M_RPTR: begin
          r_load = 1'b1;
          launch = acc_grant;
          l_addr = IA_W'(hreg_wdata);
        end
        OFF_M_WPTR: w_load = 1'b1;
        OFF_M_WDAT: begin
          launch = acc_grant; w_step = acc_grant; deny = !acc_grant;
          l_we = 1'b1; l_addr = wptr;
        end
        OFF_P_WDAT: begin
          launch = acc_grant; deny = !acc_grant;
          l_we = 1'b1; l_per = 1'b1;
          l_addr = IA_W'(pwa.off); l_be = cnt_to_be(pwa.cnt);
        end
        default: ;
      endcase
    end else if (is_rd) begin
      unique case (hreg_addr)
        OFF_M_RDAT: begin
          launch = acc_grant; r_step = acc_grant; deny = !acc_grant;
          l_addr = rptr + IA_W'(STEP);
        end
        OFF_P_RDAT: begin
          launch = acc_grant; deny = !acc_grant; l_per = 1'b1;
          l_addr = IA_W'(pra.off); l_be = cnt_to_be(pra.cnt);
        end
        default: ;
      endcase
    end
  end

  imw_ptr #(.W(IA_W), .STEP(STEP)) u_rptr (
    .clk(clk), .rst(rst), .load(r_load), .ld_val(IA_W'(hreg_wdata)),
    .step(r_step), .q(rptr));

  imw_ptr #(.W(IA_W), .STEP(STEP)) u_wptr (
    .clk(clk), .rst(rst), .load(w_load), .ld_val(IA_W'(hreg_wdata)),
    .step(w_step), .q(wptr));

  imw_xfer #(.AW(IA_W), .DW(DATA_W)) u_xfer (
    .clk(clk), .rst(rst), .launch(launch), .l_we(l_we), .l_per(l_per),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_be(l_be), .ready(ireq_ready),
    .valid(ireq_valid), .we(ireq_we), .per(ireq_periph), .addr(ireq_addr),
    .wdata(ireq_wdata), .be(ireq_be), .cmpl(cmpl));

  assign busy = ireq_valid | prd_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwa         <= '0;
      pra         <= '0;
      rbuf        <= '0;
      prd_wait    <= 1'b0;
      acc_err     <= 1'b0;
      hreg_rdata  <= '0;
      hreg_rvalid <= 1'b0;
    end else begin
      hreg_rvalid <= 1'b0;
      if (deny) acc_err <= 1'b1;
      if (is_wr && hreg_addr == OFF_P_WADR) pwa <= '{cnt: hreg_wdata[25:24], off: hreg_wdata[15:0]};
      if (is_wr && hreg_addr == OFF_P_RADR) pra <= '{cnt: hreg_wdata[25:24], off: hreg_wdata[15:0]};
      if (is_rd) begin
        hreg_rvalid <= 1'b1;
        unique case (hreg_addr)
          OFF_M_RPTR: hreg_rdata <= DATA_W'(rptr);
          OFF_M_WPTR: hreg_rdata <= DATA_W'(wptr);
          OFF_P_WADR: hreg_rdata <= {6'd0, pwa.cnt, 8'd0, pwa.off};
          OFF_P_RADR: hreg_rdata <= {6'd0, pra.cnt, 8'd0, pra.off};
          OFF_M_RDAT: hreg_rdata <= acc_grant ? rbuf : ALL_ONES;
          OFF_P_RDAT: begin
            hreg_rdata <= ALL_ONES;
            if (acc_grant) begin
              hreg_rvalid <= 1'b0;
              prd_wait    <= 1'b1;
            end
          end
          default: hreg_rdata <= '0;
        endcase
      end
      if (cmpl && !ireq_we) begin
        if (ireq_periph) begin
          hreg_rdata  <= ireq_rdata & be_mask(ireq_be);
          hreg_rvalid <= 1'b1;
          prd_wait    <= 1'b0;
        end else begin
          rbuf <= ireq_rdata;
        end
      end
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    acc_err |=> acc_err);
  p_nogrant_noreq_r8: assert property (@(posedge clk) disable iff (rst)
    ((hreg_wr || hreg_rd) && !acc_grant && !busy) |=> !ireq_valid);
  p_wdat_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (hreg_wr && hreg_addr == OFF_M_WDAT && acc_grant && !busy)
      |=> (ireq_valid && ireq_we && !ireq_periph));
  p_mem_be_r2: assert property (@(posedge clk) disable iff (rst)
    (ireq_valid && !ireq_periph) |-> ireq_be == '1);
  p_be_shape_r6: assert property (@(posedge clk) disable iff (rst)
    ireq_valid |-> $onehot({1'b0, ireq_be} + (BE_W+1)'(1)));
  p_rvalid_next_r11: assert property (@(posedge clk) disable iff (rst)
    (hreg_rd && !busy && !(hreg_addr == OFF_P_RDAT && acc_grant)) |=> hreg_rvalid);
endmodule

// File: tb/tb_mem_window_port.sv
module tb_mem_window_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_grant = 1'b1;
  logic        hreg_wr = 1'b0, hreg_rd = 1'b0;
  logic [7:0]  hreg_addr = '0;
  logic [31:0] hreg_wdata = '0;
  logic [31:0] hreg_rdata;
  logic        hreg_rvalid, busy, acc_err;
  logic        ireq_valid, ireq_we, ireq_periph;
  logic [31:0] ireq_addr, ireq_wdata;
  logic [3:0]  ireq_be;
  logic        ireq_ready = 1'b0;
  logic [31:0] ireq_rdata;

  int nvec = 0, nfail = 0;
  int stall = 0, wcnt = 0;
  logic [31:0] mem  [64];
  logic [31:0] preg [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_port dut (
    .clk(clk), .rst(rst), .acc_grant(acc_grant), .hreg_wr(hreg_wr), .hreg_rd(hreg_rd),
    .hreg_addr(hreg_addr), .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata),
    .hreg_rvalid(hreg_rvalid), .busy(busy), .acc_err(acc_err), .ireq_valid(ireq_valid),
    .ireq_we(ireq_we), .ireq_periph(ireq_periph), .ireq_addr(ireq_addr), .ireq_be(ireq_be),
    .ireq_wdata(ireq_wdata), .ireq_ready(ireq_ready), .ireq_rdata(ireq_rdata));

  // Internal responder: memory and peripheral space with adjustable latency
  assign ireq_rdata = ireq_periph ? preg[ireq_addr[5:2]] : mem[ireq_addr[7:2]];

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE0000 + i;
    for (int i = 0; i < 16; i++) preg[i] = 32'h55000000 + i;
  end

  always @(posedge clk) begin
    ireq_ready <= 1'b0;
    if (ireq_valid && !ireq_ready) begin
      if (wcnt >= stall) begin ireq_ready <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end
    if (ireq_valid && ireq_ready && ireq_we) begin
      for (int b = 0; b < 4; b++) if (ireq_be[b]) begin
        if (ireq_periph) preg[ireq_addr[5:2]][b*8 +: 8] <= ireq_wdata[b*8 +: 8];
        else             mem[ireq_addr[7:2]][b*8 +: 8]  <= ireq_wdata[b*8 +: 8];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] off, input logic [31:0] val, input logic gnt);
    wait_idle();
    acc_grant = gnt; hreg_addr = off; hreg_wdata = val; hreg_wr = 1'b1;
    @(negedge clk);
    hreg_wr = 1'b0; acc_grant = 1'b1;
  endtask

  task automatic host_rd(input logic [7:0] off, input logic gnt, output logic [31:0] val);
    wait_idle();
    acc_grant = gnt; hreg_addr = off; hreg_rd = 1'b1;
    @(negedge clk);
    hreg_rd = 1'b0; acc_grant = 1'b1;
    if (off == 8'h50 && gnt) begin
      for (int k = 0; k < 100 && !hreg_rvalid; k++) @(negedge clk);
    end else begin
      check("R11 rvalid", {31'd0, hreg_rvalid}, 32'd1);
    end
    val = hreg_rdata;
  endtask

  typedef struct packed {
    logic        rd;
    logic        gnt;
    logic [7:0]  off;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h10, 32'h00000020, 8'd3},  // R3 load write pointer
    '{1'b0, 1'b1, 8'h18, 32'hDEAD0001, 8'd2},  // R2 write mem[8]
    '{1'b0, 1'b1, 8'h18, 32'hDEAD0002, 8'd2},  // R2 write mem[9]
    '{1'b1, 1'b1, 8'h10, 32'h00000028, 8'd3},  // R3 pointer moved by 8
    '{1'b0, 1'b1, 8'h0C, 32'h00000020, 8'd4},  // R4 load read pointer
    '{1'b1, 1'b1, 8'h1C, 32'hDEAD0001, 8'd4},  // R4 first dword
    '{1'b1, 1'b1, 8'h1C, 32'hDEAD0002, 8'd5},  // R5 prefetched next
    '{1'b1, 1'b1, 8'h1C, 32'hC0DE000A, 8'd5},  // R5 untouched mem[10]
    '{1'b1, 1'b1, 8'h0C, 32'h0000002C, 8'd5},  // R5 read pointer +12
    '{1'b1, 1'b1, 8'h10, 32'h00000028, 8'd5},  // R5 write pointer independent
    '{1'b0, 1'b1, 8'h44, 32'h01000008, 8'd6},  // R6 two bytes at 0x8
    '{1'b0, 1'b1, 8'h4C, 32'hAABBCCDD, 8'd6},  // R6 partial write
    '{1'b1, 1'b1, 8'h44, 32'h01000008, 8'd10}, // R10 readback
    '{1'b0, 1'b1, 8'h48, 32'h03000008, 8'd7},  // R7 full dword read setup
    '{1'b1, 1'b1, 8'h50, 32'h5500CCDD, 8'd6},  // R6 only low two bytes written
    '{1'b0, 1'b1, 8'h48, 32'h00000008, 8'd7},  // R7 one byte
    '{1'b1, 1'b1, 8'h50, 32'h000000DD, 8'd7},  // R7 zero fill
    '{1'b0, 1'b1, 8'h48, 32'hFFFF0004, 8'd10}, // R10 junk bits dropped
    '{1'b1, 1'b1, 8'h48, 32'h03000004, 8'd10}, // R10 fields only
    '{1'b0, 1'b0, 8'h18, 32'h12345678, 8'd8},  // R8 denied write
    '{1'b1, 1'b1, 8'h10, 32'h00000028, 8'd8},  // R8 write pointer held
    '{1'b1, 1'b0, 8'h1C, 32'hFFFFFFFF, 8'd8},  // R8 denied read
    '{1'b1, 1'b1, 8'h0C, 32'h0000002C, 8'd8},  // R8 read pointer held
    '{1'b1, 1'b1, 8'h1C, 32'hC0DE000B, 8'd5},  // R5 buffered mem[11]
    '{1'b0, 1'b1, 8'h0C, 32'h00000028, 8'd8},  // R8 reread mem[10]
    '{1'b1, 1'b1, 8'h1C, 32'hC0DE000A, 8'd8},  // R8 denied write left mem[10]
    '{1'b1, 1'b0, 8'h50, 32'hFFFFFFFF, 8'd8}   // R8 denied peripheral read
  };

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    check("R1 ireq_valid", {31'd0, ireq_valid}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 acc_err", {31'd0, acc_err}, 32'd0);
    host_rd(8'h0C, 1'b1, v); check("R1 read pointer", v, 32'd0);
    host_rd(8'h10, 1'b1, v); check("R1 write pointer", v, 32'd0);
    host_rd(8'h44, 1'b1, v); check("R1 peripheral address", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        host_rd(VECS[i].off, VECS[i].gnt, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].val);
      end else begin
        host_wr(VECS[i].off, VECS[i].val, VECS[i].gnt);
      end
    end

    // R8 sticky error after denied accesses
    wait_idle();
    check("R8 acc_err sticky", {31'd0, acc_err}, 32'd1);

    // R9 slow responder: requests must hold until ready
    stall = 4;
    host_wr(8'h44, 32'h02000010, 1'b1);
    host_wr(8'h4C, 32'h99887766, 1'b1);
    host_wr(8'h48, 32'h03000010, 1'b1);
    host_rd(8'h50, 1'b1, v); check("R9 slow peripheral round trip", v, 32'h55887766);
    host_wr(8'h0C, 32'h00000000, 1'b1);
    host_rd(8'h1C, 1'b1, v); check("R9 slow memory prefetch", v, 32'hC0DE0000);
    host_rd(8'h1C, 1'b1, v); check("R9 slow second dword", v, 32'hC0DE0001);
    wait_idle();
    check("R8 acc_err still set", {31'd0, acc_err}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule